// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo PCM serial stream into parallel samples. An external master drives the bit clock, the word clock and the data line, and the block follows both clocks as a slave. All three lines are resynchronised into the system clock domain. Each bit is taken on a detected rising edge of the bit clock. A 3-bit format code picks the framing: right-aligned words of 16, 20 or 24 bits, left-aligned 24-bit words, or the I2S layout with its one-bit delay. In every framing the data arrives most significant bit first, in two's complement.

A shift engine gathers the bits of each half-frame and emits one word at each word-clock transition. A word from a right-aligned framing is sign-extended to 24 bits. A small state machine pairs the words into frames. It has three states. UNSYNC drops the partial word that is pending when the stream first starts. NEED_LEFT waits for a left word. HOLD_LEFT keeps a left word until its right partner arrives. The transitions are: UNSYNC to NEED_LEFT on the first word; NEED_LEFT to HOLD_LEFT on a left word; HOLD_LEFT to HOLD_LEFT on a further left word, which replaces the one held; HOLD_LEFT to NEED_LEFT on a right word, which publishes the frame. A right word that arrives in NEED_LEFT is dropped. Both outputs then change together, and a one-cycle strobe marks them.

Top module: `audio_serial_rx`

## Requirements
- R1: Codes 000, 001 and 100 select right-aligned framing of 16, 20 and 24 bits. The output is the last 16, 20 or 24 bits received before each word-clock transition, sign-extended to 24 bits.
- R2: Code 010 selects left-aligned 24-bit framing. The bit taken at the word-clock transition is the sample MSB, and any bits after the 24th of a half-frame are ignored.
- R3: In left-aligned mode, a 16-bit source that follows its data with zero bits is received as its value shifted left by 8.
- R4: Code 011 selects I2S framing. The MSB is the second bit of the half-frame, and a low word clock marks the left channel. With exactly 24 bit clocks per half-frame, the LSB is the bit taken at the next word-clock transition.
- R5: In every mode other than I2S, a high word clock marks the left channel.
- R6: Data is taken only on rising bit-clock edges. Changes on the data line while the bit clock is high have no effect.
- R7: frame_valid is high for exactly one cycle per frame, once the right word has been captured. left_out and right_out change only in that cycle.
- R8: Codes 101, 110 and 111 behave as code 010.
- R9: A change of format code takes effect at the next frame boundary. The frame in progress, and the right half that ends at that boundary, are decoded in the old format.
- R10: The block decodes correctly at the minimum bit-clock rates: 16, 20 and 24 bit clocks per half-frame for the 16-bit, 20-bit and 24-bit framings.
- R11: After reset, frame_valid is low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Framing code |
| bit_clk | input | 1 | Serial bit clock from the master |
| word_clk | input | 1 | Left/right word clock from the master |
| ser_data | input | 1 | Serial audio data |
| left_out | output | 24 | Left sample, sign-extended |
| right_out | output | 24 | Right sample, sign-extended |
| frame_valid | output | 1 | One-cycle strobe when a new frame is on the outputs |

## Verification
The assertions assume that each bit-clock half-period lasts at least three system-clock cycles. They also assume that the word clock and the data line change only while the bit clock is low, so that the resynchronised lines stay aligned at every detected rising edge. The bench holds each bit-clock phase for four system cycles. It changes data and word clock together with the falling edge, and it toggles the data line only after the rising edge has been resynchronised. Format changes are applied only between bits, and every scenario starts with warm-up frames, so checks never fall on the partial frames that follow a mode switch.

// File: rtl/asr_pkg.sv
package asr_pkg;

    typedef enum logic [2:0] {
        MD_LSB16,
        MD_LSB20,
        MD_MSB24,
        MD_I2S24,
        MD_LSB24
    } mode_e;

    typedef enum logic [1:0] {
        ST_UNSYNC,
        ST_NEED_LEFT,
        ST_HOLD_LEFT
    } pack_state_e;

    function automatic mode_e decode_fmt(logic [2:0] code);
        case (code)
            3'b000:  return MD_LSB16;
            3'b001:  return MD_LSB20;
            3'b011:  return MD_I2S24;
            3'b100:  return MD_LSB24;
            default: return MD_MSB24;
        endcase
    endfunction

    function automatic logic left_level(mode_e m);
        return (m == MD_I2S24) ? 1'b0 : 1'b1;
    endfunction

    function automatic int kept_bits(mode_e m, int full);
        case (m)
            MD_LSB16: return 16;
            MD_LSB20: return 20;
            default:  return full;
        endcase
    endfunction

endpackage

// File: rtl/asr_in_sync.sv
module asr_in_sync #(
    parameter int STAGES = 2,
    parameter int LANES  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] synced,
    output logic             lane0_rise
);
    logic [LANES-1:0] pipe [STAGES];
    logic             lane0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            lane0_q <= 1'b0;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            lane0_q <= pipe[STAGES-1][0];
        end
    end

    assign synced     = pipe[STAGES-1];
    assign lane0_rise = pipe[STAGES-1][0] & ~lane0_q;

endmodule

// File: rtl/asr_shift_engine.sv
module asr_shift_engine
    import asr_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   fmt_sel,
    input  logic         bit_rise,
    input  logic         wclk_s,
    input  logic         data_s,
    output logic         word_stb,
    output logic [W-1:0] word,
    output logic         word_left
);
    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] LAST_MSB = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] LAST_I2S = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;

    mode_e          mode_q, mode_next;
    logic           primed, lr_prev, edge_seen, boundary;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]   sh, word_src;

    function automatic logic [W-1:0] pick(mode_e m, logic [W-1:0] s);
        int amt;
        logic signed [W-1:0] t;
        amt = W - kept_bits(m, W);
        t   = s << amt;
        return t >>> amt;
    endfunction

    always_comb begin
        edge_seen = primed && (wclk_s != lr_prev);
        boundary  = edge_seen && (wclk_s == left_level(mode_q));
        mode_next = (!primed || boundary) ? decode_fmt(fmt_sel) : mode_q;
        // I2S at exactly W clocks per half: the LSB lands on the transition bit
        word_src  = (mode_q == MD_I2S24 && cnt == LAST_I2S) ? {sh[W-2:0], data_s} : sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MD_MSB24;
            primed    <= 1'b0;
            lr_prev   <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
            word_stb  <= 1'b0;
            word      <= '0;
            word_left <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (bit_rise) begin
                primed  <= 1'b1;
                lr_prev <= wclk_s;
                mode_q  <= mode_next;
                if (edge_seen) begin
                    word_stb  <= 1'b1;
                    word      <= pick(mode_q, word_src);
                    word_left <= (lr_prev == left_level(mode_q));
                    cnt       <= CNT_W'(1);
                    case (mode_next)
                        MD_MSB24: sh <= {{(W-1){1'b0}}, data_s};
                        MD_I2S24: sh <= '0;
                        default:  sh <= {sh[W-2:0], data_s};
                    endcase
                end else begin
                    if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
                    case (mode_q)
                        MD_MSB24: if (cnt <= LAST_MSB) sh <= {sh[W-2:0], data_s};
                        MD_I2S24: if (cnt >= CNT_W'(1) && cnt <= LAST_I2S) sh <= {sh[W-2:0], data_s};
                        default:  sh <= {sh[W-2:0], data_s};
                    endcase
                end
            end
        end
    end

    // R9: once running, the decode mode moves only together with a word hand-off
    assert_mode_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(primed) && mode_q != $past(mode_q)) |-> word_stb);

    // R1: a 16-bit right-aligned word leaves the engine sign-extended
    assert_lsb16_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && $past(mode_q) == MD_LSB16) |-> (word[W-1:16] == {(W-16){word[15]}}));

    // R6: a word is only produced right after a detected rising bit edge
    assert_word_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> $past(bit_rise));

endmodule

// File: rtl/asr_frame_pack.sv
module asr_frame_pack
    import asr_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_stb,
    input  logic [W-1:0] word,
    input  logic         word_left,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out,
    output logic         frame_valid
);
    pack_state_e  state, state_next;
    logic [W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNSYNC;
        else        state <= state_next;
    end

    always_comb begin
        state_next = state;
        if (word_stb) begin
            unique case (state)
                ST_UNSYNC:    state_next = ST_NEED_LEFT;
                ST_NEED_LEFT: state_next = word_left ? ST_HOLD_LEFT : ST_NEED_LEFT;
                ST_HOLD_LEFT: state_next = word_left ? ST_HOLD_LEFT : ST_NEED_LEFT;
                default:      state_next = ST_UNSYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held        <= '0;
            left_out    <= '0;
            right_out   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (word_stb && state != ST_UNSYNC) begin
                if (word_left) begin
                    held <= word;
                end else if (state == ST_HOLD_LEFT) begin
                    left_out    <= held;
                    right_out   <= word;
                    frame_valid <= 1'b1;
                end
            end
        end
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(left_out) && $stable(right_out)));

    assert_valid_from_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(state) == ST_HOLD_LEFT && $past(!word_left)));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asr_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_sel,
    input  logic                bit_clk,
    input  logic                word_clk,
    input  logic                ser_data,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                frame_valid
);
    localparam int LANES = 3;

    logic [LANES-1:0]    lines_s;
    logic                bit_rise, word_stb, word_left;
    logic [SAMPLE_W-1:0] word;

    asr_in_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw        ({ser_data, word_clk, bit_clk}),
        .synced     (lines_s),
        .lane0_rise (bit_rise)
    );

    asr_shift_engine #(.W(SAMPLE_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .bit_rise  (bit_rise),
        .wclk_s    (lines_s[1]),
        .data_s    (lines_s[2]),
        .word_stb  (word_stb),
        .word      (word),
        .word_left (word_left)
    );

    asr_frame_pack #(.W(SAMPLE_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_stb    (word_stb),
        .word        (word),
        .word_left   (word_left),
        .left_out    (left_out),
        .right_out   (right_out),
        .frame_valid (frame_valid)
    );

endmodule

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt = 3'b010;
    logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
    logic [23:0] left_out, right_out;
    logic        frame_valid;

    int total = 0, bad = 0;
    int ncap = 0, pulse_bad = 0;
    bit prev_v = 1'b0;
    logic carry = 1'b0;
    logic [23:0] cap_l [256];
    logic [23:0] cap_r [256];

    always #10 clk = ~clk;

    audio_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt), .bit_clk(bclk), .word_clk(wclk),
        .ser_data(sdata), .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                if (ncap < 256) begin
                    cap_l[ncap] = left_out;
                    cap_r[ncap] = right_out;
                end
                ncap++;
                if (prev_v) pulse_bad++;
            end
            prev_v = frame_valid;
        end
    end

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp_min);
        total++;
        if (act < exp_min) begin
            bad++;
            $display("FAIL %s: got %0d expected at least %0d", tag, act, exp_min);
        end
    endtask

    function automatic int width_of(input int md);
        if (md == 0) return 16;
        if (md == 1) return 20;
        return 24;
    endfunction

    function automatic logic [23:0] expect_val(input int md, input logic [23:0] v);
        int n;
        logic signed [23:0] t;
        n = width_of(md);
        t = $signed(v << (24 - n));
        return t >>> (24 - n);
    endfunction

    // md: 0/1/4 right-aligned 16/20/24, 2 left-aligned, 3 I2S
    function automatic logic bit_of(input int md, input logic [23:0] v, input int k, input int bph);
        int n, pos;
        logic pad;
        pad = (k % 2 == 1);
        if (md == 2) return (k < 24) ? v[23-k] : pad;
        if (md == 3) begin
            if (k == 0) return (bph < 25) ? carry : ~pad;
            return (k <= 24) ? v[24-k] : pad;
        end
        n = width_of(md);
        pos = k - (bph - n);
        return (pos >= 0) ? v[n-1-pos] : pad;
    endfunction

    task automatic send_bit(input logic d, input logic w);
        bclk = 1'b0; sdata = d; wclk = w;
        repeat (HALF) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        sdata = ~d;   // R6: wiggle while the bit clock is high
        repeat (HALF - 2) @(negedge clk);
    endtask

    task automatic send_half(input int md, input logic [23:0] v, input int bph, input logic w,
                             input int chg_k, input logic [2:0] chg_code);
        for (int k = 0; k < bph; k++) begin
            if (k == chg_k) fmt = chg_code;
            send_bit(bit_of(md, v, k, bph), w);
        end
        carry = v[0];
    endtask

    task automatic send_frame(input int md, input logic [23:0] l, input logic [23:0] r,
                              input int bph, input logic lvl);
        send_half(md, l, bph, lvl, -1, 3'b000);
        send_half(md, r, bph, ~lvl, -1, 3'b000);
    endtask

    task automatic run_case(input logic [2:0] code, input int md, input int bph,
                            input logic [23:0] seed, input bit src16, input string tag);
        logic [23:0] el [3];
        logic [23:0] er [3];
        logic lvl;
        int n0;
        fmt = code;
        lvl = (md == 3) ? 1'b0 : 1'b1;
        repeat (2) send_frame(md, 24'h5AA5C3, 24'hA55A3C, bph, lvl);
        n0 = ncap;
        for (int i = 0; i < 3; i++) begin
            logic [23:0] a, b;
            a = 24'(seed * 24'(i + 3)) ^ 24'h8F0F1;
            b = ~a + seed;
            if (i == 1) a = {1'b1, a[22:0]} ^ 24'h00F000;
            if (src16) begin a = {a[15:0], 8'h00}; b = {b[15:0], 8'h00}; end
            send_frame(md, a, b, bph, lvl);
            el[i] = expect_val(md, a);
            er[i] = expect_val(md, b);
        end
        send_half(md, 24'h123456, bph, lvl, -1, 3'b000);
        repeat (8) @(negedge clk);
        chk_int({tag, " frame count"}, ncap - n0, 3);
        for (int i = 0; i < 3; i++) begin
            chk({tag, " left"},  cap_l[ncap-3+i], el[i]);
            chk({tag, " right"}, cap_r[ncap-3+i], er[i]);
        end
    endtask

    task automatic test_reset();
        repeat (5) @(negedge clk);
        chk("R11 valid after reset", {23'b0, frame_valid}, 24'h0);
        chk("R11 left after reset", left_out, 24'h0);
        chk("R11 right after reset", right_out, 24'h0);
    endtask

    task automatic test_fmt_switch();
        logic [23:0] a, b, c, d;
        a = 24'hC3A501; b = 24'h1E2D3C; c = 24'h00F00D; d = 24'h7F8001;
        fmt = 3'b010;
        repeat (2) send_frame(2, 24'h0F0F0F, 24'hF0F0F0, 32, 1'b1);
        // R9: code switches mid left half; this frame still decodes left-aligned
        send_half(2, a, 32, 1'b1, 10, 3'b000);
        send_half(2, b, 32, 1'b0, -1, 3'b000);
        send_half(0, c, 32, 1'b1, -1, 3'b000);
        repeat (8) @(negedge clk);
        chk("R9 old format left", cap_l[ncap-1], a);
        chk("R9 old format right", cap_r[ncap-1], b);
        send_half(0, d, 32, 1'b0, -1, 3'b000);
        send_half(0, 24'h000000, 32, 1'b1, -1, 3'b000);
        repeat (8) @(negedge clk);
        chk("R9 new format left", cap_l[ncap-1], expect_val(0, c));
        chk("R9 new format right", cap_r[ncap-1], expect_val(0, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_case(3'b000, 0, 32, 24'h3A5C71, 1'b0, "R1 R5 R6 lsb16");
        run_case(3'b000, 0, 16, 24'h19E3B7, 1'b0, "R10 lsb16 min");
        run_case(3'b001, 1, 20, 24'h6C0F35, 1'b0, "R1 R10 lsb20 min");
        run_case(3'b100, 4, 32, 24'hB4D2E9, 1'b0, "R1 R6 lsb24");
        run_case(3'b010, 2, 32, 24'h27F1A3, 1'b0, "R2 R5 msb24");
        run_case(3'b010, 2, 24, 24'h5D8E13, 1'b0, "R10 msb24 min");
        run_case(3'b010, 2, 32, 24'h4B9A6D, 1'b1, "R3 msb16 source");
        run_case(3'b011, 3, 32, 24'h71C3E5, 1'b0, "R4 i2s");
        run_case(3'b011, 3, 24, 24'h2E6B95, 1'b0, "R4 R10 i2s min");
        run_case(3'b110, 2, 32, 24'h93A7C1, 1'b0, "R8 reserved code");
        test_fmt_switch();
        total++;
        if (pulse_bad != 0) begin
            bad++;
            $display("FAIL R7 strobe width: got %0d long pulses expected 0", pulse_bad);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule